// File: doc/BRIEF.md
# Fixed-Point State-Variable Filter Core

This block is the arithmetic heart of a two-integrator-loop biquad running as a fixed-point IIR filter. It holds three signed state registers: highpass, bandpass and lowpass. It advances them either by one update per tick, or by a requested number of elapsed cycles that it breaks into sub-steps of at most eight cycles, one sub-step per clock.

The cutoff setting is an 11-bit code written in two parts, a high byte and a low 3-bit field. The code is driven out as an address to an external cutoff-frequency table, which returns a frequency in Hz one clock later. From that frequency the block forms an angular-rate coefficient. The time base uses a 1.048576 prescale, so division by one million becomes a right shift. The coefficient is then clamped twice: once for single-cycle stepping and once for multi-cycle stepping. A 4-bit resonance setting selects a reciprocal-Q coefficient from a small computed table.

The filter input sum `vin` comes from the surrounding voice mixer, and the three state outputs go on to the output mixer.

Top module: `svf_core`

## Requirements
- R1: The cutoff code on `freq_addr` is 11 bits. A high write loads bits 10:3 from `cut_hi_val` and leaves bits 2:0 unchanged. A low write loads bits 2:0 from `cut_lo_val` and leaves bits 10:3 unchanged. The new code appears on `freq_addr` one clock after the write.
- R2: `coef_w1` equals min(trunc(2π·1.048576·f), 105414), where f is the `freq_hz` value sampled at the previous clock edge. 105414 is the value at 16000 Hz.
- R3: `coef_wdt` equals min(trunc(2π·1.048576·f), 26353) for the same f. 26353 is the value at 4000 Hz.
- R4: `coef_q` equals trunc(1024/(0.707 + res/15)) for the resonance code res. Resonance 0 gives 1448 and resonance 15 gives 599. The value is registered one clock after the resonance register changes, and a resonance write takes effect one clock after it is made.
- R5: A `tick` accepted while idle performs one update at the next edge. The update computes dbp = (w1·hp)>>>20 and dlp = (w1·bp)>>>20 from the old state. It then sets bp -= dbp and lp -= dlp, and finally hp = ((bp·q)>>>10) − lp − vin using the new bp and lp. All arithmetic is 32-bit signed with 64-bit products.
- R6: A `span_req` of N>0 cycles latches `vin` and runs ceil(N/8) sub-steps, one per clock. Each sub-step covers L = min(8, remaining) cycles and uses wdt = (coef_wdt·L)>>>6, with shifts of 14 in place of 20, in the same update order.
- R7: `busy` is high from the edge that accepts a span until the edge of its final sub-step, so it is high for exactly ceil(N/8) cycles. `done` is a one-cycle pulse in the cycle after the final sub-step. A span of N=0 pulses `done` without raising `busy` or changing any state.
- R8: `tick` and `span_req` are ignored while `busy` is high. When both are raised while idle, the span is taken and the tick is dropped.
- R9: The state outputs hold their values in any cycle that performs no update.
- R10: Reset clears the cutoff code, the resonance, all three state registers, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cut_hi_we | input | 1 | Write strobe for cutoff bits 10:3 |
| cut_hi_val | input | 8 | Value for cutoff bits 10:3 |
| cut_lo_we | input | 1 | Write strobe for cutoff bits 2:0 |
| cut_lo_val | input | 3 | Value for cutoff bits 2:0 |
| res_we | input | 1 | Write strobe for resonance |
| res_val | input | 4 | Resonance code |
| freq_addr | output | 11 | Current cutoff code, used as the table address |
| freq_hz | input | 16 | Cutoff frequency in Hz from the table (one-cycle latency) |
| vin | input | 32 | Signed filter input sum |
| tick | input | 1 | Request one single-cycle update |
| span_req | input | 1 | Request a multi-cycle update |
| span_cycles | input | 16 | Number of elapsed cycles for a span |
| busy | output | 1 | Span in progress |
| done | output | 1 | One-cycle pulse after a span completes |
| hp_out | output | 32 | Signed highpass state |
| bp_out | output | 32 | Signed bandpass state |
| lp_out | output | 32 | Signed lowpass state |
| coef_w1 | output | 32 | Single-step angular coefficient |
| coef_wdt | output | 32 | Multi-step angular coefficient |
| coef_q | output | 16 | Reciprocal-Q coefficient |

## Verification
The coefficients are tried at a top cutoff that exceeds both ceilings, at a low cutoff that reaches neither, and at many random codes. Together these separate the single-step clamp from the multi-step clamp. Spans of 1, 8, 9, 17 and 0 cycles exercise the partial final chunk, the exact multiple of eight and the empty request. A random `vin` driven during a span shows whether the input is latched. Ticks and spans raised together, or raised while busy, show the priority and ignore rules. Random mixes of resonance, cutoff and input, stepped both ways, are compared with a bench model. Because that model updates bp before hp, any error in the update order is exposed.

// File: rtl/svf_pkg.sv
package svf_pkg;

   // Fractional bits of the fixed-point form of 2*pi*1.048576.
   localparam int SVF_W0_FRAC = 32;
   localparam real SVF_TWO_PI_PRE = 2.0 * 3.14159265358979323846 * 1.048576;
   // Floor of the scaled constant (cast rounds, so step down by half).
   localparam longint SVF_W0_K = longint'(SVF_TWO_PI_PRE * (2.0 ** SVF_W0_FRAC) - 0.5);

   // Angular coefficient for a frequency in Hz, truncated.
   function automatic longint hz_to_w0(input longint f_hz);
      return (f_hz * SVF_W0_K) >>> SVF_W0_FRAC;
   endfunction

   // Reciprocal Q scaled by 1024: 1024 / (0.707 + r/(n-1)), in exact integers.
   function automatic int q_coef(input int r, input int n);
      longint num;
      longint den;
      num = longint'(1024) * 1000 * longint'(n - 1);
      den = longint'(707) * longint'(n - 1) + longint'(1000) * longint'(r);
      return int'(num / den);
   endfunction

endpackage

// File: rtl/svf_regs.sv
// Cutoff code and resonance registers.
module svf_regs #(
   parameter int CUT_W = 11,
   parameter int LO_W  = 3,
   parameter int RES_W = 4,
   localparam int HI_W = CUT_W - LO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_we,
   input  logic [HI_W-1:0]  hi_val,
   input  logic             lo_we,
   input  logic [LO_W-1:0]  lo_val,
   input  logic             res_we,
   input  logic [RES_W-1:0] res_val,
   output logic [CUT_W-1:0] cut_code,
   output logic [RES_W-1:0] res_code
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cut_code <= '0;
         res_code <= '0;
      end else begin
         if (hi_we) cut_code[CUT_W-1:LO_W] <= hi_val;
         if (lo_we) cut_code[LO_W-1:0]     <= lo_val;
         if (res_we) res_code <= res_val;
      end
   end

endmodule

// File: rtl/svf_coef.sv
// Angular and resonance coefficients with the two stability ceilings.
module svf_coef #(
   parameter int FREQ_W    = 16,
   parameter int RES_W     = 4,
   parameter int DW        = 32,
   parameter int QW        = 16,
   parameter int CEIL1_HZ  = 16000,
   parameter int CEILDT_HZ = 4000,
   parameter bit REG_COEF  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FREQ_W-1:0]    freq_hz,
   input  logic [RES_W-1:0]     res_code,
   output logic signed [DW-1:0] coef_w1,
   output logic signed [DW-1:0] coef_wdt,
   output logic [QW-1:0]        coef_q
);

   localparam int     RES_N   = 1 << RES_W;
   localparam longint CAP1    = svf_pkg::hz_to_w0(longint'(CEIL1_HZ));
   localparam longint CAPDT   = svf_pkg::hz_to_w0(longint'(CEILDT_HZ));
   localparam logic [QW-1:0] Q_RST = QW'(svf_pkg::q_coef(0, RES_N));

   logic [QW-1:0] q_rom [RES_N];

   for (genvar gi = 0; gi < RES_N; gi++) begin : g_qrom
      assign q_rom[gi] = QW'(svf_pkg::q_coef(gi, RES_N));
   end

   longint w0_raw;
   longint w1_raw;
   longint wdt_raw;

   always_comb begin
      w0_raw  = svf_pkg::hz_to_w0(longint'(freq_hz));
      w1_raw  = (w0_raw > CAP1)  ? CAP1  : w0_raw;
      wdt_raw = (w0_raw > CAPDT) ? CAPDT : w0_raw;
   end

   if (REG_COEF) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            coef_w1  <= '0;
            coef_wdt <= '0;
            coef_q   <= Q_RST;
         end else begin
            coef_w1  <= DW'(w1_raw);
            coef_wdt <= DW'(wdt_raw);
            coef_q   <= q_rom[res_code];
         end
      end
   end else begin : g_comb
      assign coef_w1  = DW'(w1_raw);
      assign coef_wdt = DW'(wdt_raw);
      assign coef_q   = q_rom[res_code];
   end

endmodule

// File: rtl/svf_seq.sv
// Step sequencer: single ticks and chunked multi-cycle spans.
module svf_seq #(
   parameter int DW    = 32,
   parameter int CNT_W = 16,
   parameter int CHUNK = 8,
   localparam int LEN_W = $clog2(CHUNK + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 span_req,
   input  logic [CNT_W-1:0]     span_cycles,
   input  logic signed [DW-1:0] vin,
   output logic                 step_en,
   output logic                 step_multi,
   output logic [LEN_W-1:0]     step_len,
   output logic signed [DW-1:0] step_vi,
   output logic                 busy,
   output logic                 done
);

   logic [CNT_W-1:0]     remain_q;
   logic signed [DW-1:0] vi_q;
   logic                 take_span;
   logic                 take_tick;
   logic                 last_sub;

   always_comb begin
      take_span = span_req && !busy;
      take_tick = tick && !busy && !span_req;
      if (remain_q < CNT_W'(CHUNK)) step_len = LEN_W'(remain_q);
      else                          step_len = LEN_W'(CHUNK);
      last_sub   = (remain_q == CNT_W'(step_len));
      step_en    = take_tick || busy;
      step_multi = busy;
      step_vi    = busy ? vi_q : vin;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         remain_q <= '0;
         vi_q     <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            remain_q <= remain_q - CNT_W'(step_len);
            if (last_sub) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else if (take_span) begin
            vi_q <= vin;
            if (span_cycles == '0) begin
               done <= 1'b1;
            end else begin
               busy     <= 1'b1;
               remain_q <= span_cycles;
            end
         end
      end
   end

endmodule

// File: rtl/svf_update.sv
// One integrator-loop update of the three state values.
module svf_update #(
   parameter int DW     = 32,
   parameter int QW     = 16,
   parameter int LEN_W  = 4,
   parameter int SH1    = 20,
   parameter int SHDT   = 14,
   parameter int DT_PRE = 6,
   parameter int QSH    = 10,
   localparam int PW    = 2 * DW
) (
   input  logic signed [DW-1:0] hp,
   input  logic signed [DW-1:0] bp,
   input  logic signed [DW-1:0] lp,
   input  logic signed [DW-1:0] vi,
   input  logic signed [DW-1:0] coef_w1,
   input  logic signed [DW-1:0] coef_wdt,
   input  logic [QW-1:0]        coef_q,
   input  logic                 multi,
   input  logic [LEN_W-1:0]     len,
   output logic signed [DW-1:0] hp_n,
   output logic signed [DW-1:0] bp_n,
   output logic signed [DW-1:0] lp_n
);

   logic signed [PW-1:0] wdt_full;
   logic signed [PW-1:0] prod_b;
   logic signed [PW-1:0] prod_l;
   logic signed [PW-1:0] prod_q;
   logic signed [DW-1:0] wdt;
   logic signed [DW-1:0] k;
   logic signed [DW-1:0] dbp;
   logic signed [DW-1:0] dlp;

   always_comb begin
      wdt_full = PW'(coef_wdt) * PW'($signed({1'b0, len}));
      wdt      = DW'(wdt_full >>> DT_PRE);
      k        = multi ? wdt : coef_w1;
      prod_b   = PW'(k) * PW'(hp);
      prod_l   = PW'(k) * PW'(bp);
      if (multi) begin
         dbp = DW'(prod_b >>> SHDT);
         dlp = DW'(prod_l >>> SHDT);
      end else begin
         dbp = DW'(prod_b >>> SH1);
         dlp = DW'(prod_l >>> SH1);
      end
      bp_n   = bp - dbp;
      lp_n   = lp - dlp;
      prod_q = PW'(bp_n) * PW'($signed({1'b0, coef_q}));
      hp_n   = DW'(prod_q >>> QSH) - lp_n - vi;
   end

endmodule

// File: rtl/svf_core.sv
// State-variable filter core: registers, coefficients, sequencer, datapath.
module svf_core #(
   parameter int DW        = 32,
   parameter int CUT_W     = 11,
   parameter int LO_W      = 3,
   parameter int FREQ_W    = 16,
   parameter int RES_W     = 4,
   parameter int QW        = 16,
   parameter int CNT_W     = 16,
   parameter int CHUNK     = 8,
   parameter int CEIL1_HZ  = 16000,
   parameter int CEILDT_HZ = 4000,
   parameter int SH1       = 20,
   parameter int SHDT      = 14,
   parameter int DT_PRE    = 6,
   parameter int QSH       = 10,
   parameter bit REG_COEF  = 1'b1,
   localparam int HI_W     = CUT_W - LO_W,
   localparam int LEN_W    = $clog2(CHUNK + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cut_hi_we,
   input  logic [HI_W-1:0]      cut_hi_val,
   input  logic                 cut_lo_we,
   input  logic [LO_W-1:0]      cut_lo_val,
   input  logic                 res_we,
   input  logic [RES_W-1:0]     res_val,
   output logic [CUT_W-1:0]     freq_addr,
   input  logic [FREQ_W-1:0]    freq_hz,
   input  logic signed [DW-1:0] vin,
   input  logic                 tick,
   input  logic                 span_req,
   input  logic [CNT_W-1:0]     span_cycles,
   output logic                 busy,
   output logic                 done,
   output logic signed [DW-1:0] hp_out,
   output logic signed [DW-1:0] bp_out,
   output logic signed [DW-1:0] lp_out,
   output logic signed [DW-1:0] coef_w1,
   output logic signed [DW-1:0] coef_wdt,
   output logic [QW-1:0]        coef_q
);

   if (DW < 32) begin : g_bad_dw
      $error("svf_core: DW must be at least 32");
   end
   if (LO_W < 1 || CUT_W <= LO_W) begin : g_bad_cut
      $error("svf_core: cutoff field split is invalid");
   end
   if (CHUNK < 1 || CHUNK >= (1 << DT_PRE) * 4) begin : g_bad_chunk
      $error("svf_core: CHUNK out of range");
   end
   if (SHDT + DT_PRE != SH1) begin : g_bad_shift
      $error("svf_core: multi-step shifts must total the single-step shift");
   end

   logic [RES_W-1:0]     res_code;
   logic                 step_en;
   logic                 step_multi;
   logic [LEN_W-1:0]     step_len;
   logic signed [DW-1:0] step_vi;
   logic signed [DW-1:0] hp_n;
   logic signed [DW-1:0] bp_n;
   logic signed [DW-1:0] lp_n;

   svf_regs #(.CUT_W(CUT_W), .LO_W(LO_W), .RES_W(RES_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_we    (cut_hi_we),
      .hi_val   (cut_hi_val),
      .lo_we    (cut_lo_we),
      .lo_val   (cut_lo_val),
      .res_we   (res_we),
      .res_val  (res_val),
      .cut_code (freq_addr),
      .res_code (res_code)
   );

   svf_coef #(
      .FREQ_W(FREQ_W), .RES_W(RES_W), .DW(DW), .QW(QW),
      .CEIL1_HZ(CEIL1_HZ), .CEILDT_HZ(CEILDT_HZ), .REG_COEF(REG_COEF)
   ) coef_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_hz  (freq_hz),
      .res_code (res_code),
      .coef_w1  (coef_w1),
      .coef_wdt (coef_wdt),
      .coef_q   (coef_q)
   );

   svf_seq #(.DW(DW), .CNT_W(CNT_W), .CHUNK(CHUNK)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .span_req    (span_req),
      .span_cycles (span_cycles),
      .vin         (vin),
      .step_en     (step_en),
      .step_multi  (step_multi),
      .step_len    (step_len),
      .step_vi     (step_vi),
      .busy        (busy),
      .done        (done)
   );

   svf_update #(
      .DW(DW), .QW(QW), .LEN_W(LEN_W), .SH1(SH1), .SHDT(SHDT),
      .DT_PRE(DT_PRE), .QSH(QSH)
   ) upd_i (
      .hp       (hp_out),
      .bp       (bp_out),
      .lp       (lp_out),
      .vi       (step_vi),
      .coef_w1  (coef_w1),
      .coef_wdt (coef_wdt),
      .coef_q   (coef_q),
      .multi    (step_multi),
      .len      (step_len),
      .hp_n     (hp_n),
      .bp_n     (bp_n),
      .lp_n     (lp_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hp_out <= '0;
         bp_out <= '0;
         lp_out <= '0;
      end else if (step_en) begin
         hp_out <= hp_n;
         bp_out <= bp_n;
         lp_out <= lp_n;
      end
   end

endmodule

// File: rtl/svf_core_chk.sv
// Property checker attached to svf_core.
module svf_core_chk #(
   parameter int DW       = 32,
   parameter int CUT_W    = 11,
   parameter int LO_W     = 3,
   parameter int CEIL1_HZ = 16000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cut_hi_we,
   input logic                 cut_lo_we,
   input logic [CUT_W-1:0]     freq_addr,
   input logic                 tick,
   input logic                 span_req,
   input logic                 busy,
   input logic                 done,
   input logic signed [DW-1:0] hp_out,
   input logic signed [DW-1:0] bp_out,
   input logic signed [DW-1:0] lp_out,
   input logic signed [DW-1:0] coef_w1,
   input logic signed [DW-1:0] coef_wdt
);

   localparam longint CAP1 = svf_pkg::hz_to_w0(longint'(CEIL1_HZ));

   a_r1_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (cut_hi_we && !cut_lo_we) |=> freq_addr[LO_W-1:0] == $past(freq_addr[LO_W-1:0]));

   a_r1_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (cut_lo_we && !cut_hi_we) |=> freq_addr[CUT_W-1:LO_W] == $past(freq_addr[CUT_W-1:LO_W]));

   a_r2_w1_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      longint'(coef_w1) <= CAP1 && coef_w1 >= 0);

   a_r3_wdt_below_w1: assert property (@(posedge clk) disable iff (!rst_n)
      coef_wdt <= coef_w1);

   a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) || $past(span_req)));

   a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tick) |=> ($stable(hp_out) && $stable(bp_out) && $stable(lp_out)));

endmodule

bind svf_core svf_core_chk #(
   .DW(DW), .CUT_W(CUT_W), .LO_W(LO_W), .CEIL1_HZ(CEIL1_HZ)
) chk_i (.*);

// File: tb/svf_core_tb_top.sv
module svf_core_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cut_hi_we;
   logic [7:0]  cut_hi_val;
   logic        cut_lo_we;
   logic [2:0]  cut_lo_val;
   logic        res_we;
   logic [3:0]  res_val;
   logic [10:0] freq_addr;
   logic [15:0] freq_hz;
   logic signed [31:0] vin;
   logic        tick;
   logic        span_req;
   logic [15:0] span_cycles;
   logic        busy;
   logic        done;
   logic signed [31:0] hp_out, bp_out, lp_out, coef_w1, coef_wdt;
   logic [15:0] coef_q;

   int errors = 0;
   int checks = 0;

   // Bench model state.
   int m_hp, m_bp, m_lp;
   int m_code, m_res;

   always #(CLK_PERIOD / 2) clk = ~clk;

   svf_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .cut_hi_we(cut_hi_we), .cut_hi_val(cut_hi_val),
      .cut_lo_we(cut_lo_we), .cut_lo_val(cut_lo_val),
      .res_we(res_we), .res_val(res_val),
      .freq_addr(freq_addr), .freq_hz(freq_hz),
      .vin(vin), .tick(tick), .span_req(span_req), .span_cycles(span_cycles),
      .busy(busy), .done(done),
      .hp_out(hp_out), .bp_out(bp_out), .lp_out(lp_out),
      .coef_w1(coef_w1), .coef_wdt(coef_wdt), .coef_q(coef_q)
   );

   // External frequency table with one clock of read latency.
   function automatic int tab(input int a);
      return 220 + 9 * a;
   endfunction

   always @(posedge clk) freq_hz <= 16'(tab(int'(freq_addr)));

   function automatic int w0_of(input int f);
      return $rtoi(2.0 * 3.141592653589793 * 1.048576 * f);
   endfunction
   function automatic int w1_of(input int f);
      return (w0_of(f) < w0_of(16000)) ? w0_of(f) : w0_of(16000);
   endfunction
   function automatic int wdt_of(input int f);
      return (w0_of(f) < w0_of(4000)) ? w0_of(f) : w0_of(4000);
   endfunction
   function automatic int q_of(input int r);
      return $rtoi(1024.0 / (0.707 + r / 15.0));
   endfunction

   task automatic m_step(input int k, input int sh, input int vi);
      int dbp, dlp;
      dbp = int'((longint'(k) * longint'(m_hp)) >>> sh);
      dlp = int'((longint'(k) * longint'(m_bp)) >>> sh);
      m_bp = m_bp - dbp;
      m_lp = m_lp - dlp;
      m_hp = int'((longint'(m_bp) * longint'(q_of(m_res))) >>> 10) - m_lp - vi;
   endtask

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " hp"}, hp_out, m_hp);
      chk({req, " bp"}, bp_out, m_bp);
      chk({req, " lp"}, lp_out, m_lp);
   endtask

   task automatic idle_inputs();
      cut_hi_we = 0; cut_lo_we = 0; res_we = 0;
      tick = 0; span_req = 0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic set_cut(input int code);
      cut_hi_we = 1; cut_hi_val = 8'(code >> 3);
      cut_lo_we = 1; cut_lo_val = 3'(code);
      @(negedge clk);
      idle_inputs();
      m_code = code & 11'h7ff;
      settle();
   endtask

   task automatic set_res(input int r);
      res_we = 1; res_val = 4'(r);
      @(negedge clk);
      idle_inputs();
      m_res = r;
      settle();
   endtask

   task automatic do_tick(input int v);
      tick = 1; vin = v;
      @(negedge clk);
      tick = 0;
      m_step(w1_of(tab(m_code)), 20, v);
      chk_state("R5 tick");
   endtask

   // Span request; optionally raise tick with it and pester while busy (R8).
   task automatic do_span(input int n, input int v, input bit pester);
      int cnt, k_exp, rem, len;
      span_req = 1; span_cycles = 16'(n); vin = v;
      if (pester) tick = 1;
      @(negedge clk);
      span_req = 0; tick = 0;
      vin = int'($urandom_range(20000)) - 10000;
      k_exp = (n + 7) / 8;
      if (n == 0) begin
         chk("R7 zero span done", done, 1);
         chk("R7 zero span busy", busy, 0);
         chk_state("R7 zero span state");
         @(negedge clk);
         chk("R7 done is a pulse", done, 0);
         return;
      end
      if (pester) chk_state("R8 tick dropped with span");
      cnt = 0;
      while (busy && cnt < 100) begin
         if (pester) begin
            tick = 1; span_req = 1; span_cycles = 16'd3;
         end
         @(negedge clk);
         cnt++;
      end
      tick = 0; span_req = 0;
      chk("R7 busy cycles", cnt, k_exp);
      chk("R7 done after span", done, 1);
      rem = n;
      while (rem > 0) begin
         len = (rem < 8) ? rem : 8;
         m_step(int'((longint'(wdt_of(tab(m_code))) * len) >>> 6), 14, v);
         rem -= len;
      end
      chk_state(pester ? "R8 span while pestered" : "R6 span");
      @(negedge clk);
      chk("R7 done cleared", done, 0);
      chk_state("R9 hold after span");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      cut_hi_val = 0; cut_lo_val = 0; res_val = 0; vin = 0; span_cycles = 0;
      m_hp = 0; m_bp = 0; m_lp = 0; m_code = 0; m_res = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R10: values while in reset.
      chk("R10 busy in reset", busy, 0);
      chk("R10 done in reset", done, 0);
      chk("R10 code in reset", freq_addr, 0);
      chk_state("R10 reset");
      rst_n = 1;
      @(negedge clk);
      chk("R4 q after reset", coef_q, 1448);

      // R1: split writes keep the other field.
      cut_hi_we = 1; cut_hi_val = 8'h5A; @(negedge clk); idle_inputs();
      chk("R1 hi write", freq_addr, 11'h5A << 3);
      cut_lo_we = 1; cut_lo_val = 3'd5; @(negedge clk); idle_inputs();
      chk("R1 lo write keeps hi", freq_addr, (11'h5A << 3) | 5);
      cut_hi_we = 1; cut_hi_val = 8'h13; @(negedge clk); idle_inputs();
      chk("R1 hi write keeps lo", freq_addr, (11'h13 << 3) | 5);

      // R2/R3: top cutoff exceeds both ceilings.
      set_cut(2047);
      chk("R2 w1 ceiling", coef_w1, 105414);
      chk("R3 wdt ceiling", coef_wdt, 26353);
      // Low cutoff reaches neither ceiling.
      set_cut(10);
      chk("R2 w1 low", coef_w1, w0_of(310));
      chk("R3 wdt low", coef_wdt, w0_of(310));
      // Between ceilings.
      set_cut(1000);
      chk("R2 w1 mid", coef_w1, w1_of(tab(1000)));
      chk("R3 wdt mid", coef_wdt, 26353);

      // R4: resonance extremes.
      set_res(15);
      chk("R4 q res15", coef_q, 599);
      set_res(0);
      chk("R4 q res0", coef_q, 1448);

      // R5: impulse then free ringing.
      set_cut(600);
      do_tick(4000);
      do_tick(0);
      do_tick(-3000);
      @(negedge clk);
      chk_state("R9 hold idle");

      // R6/R7: chunk boundaries.
      do_span(1, 1500, 0);
      do_span(8, -2200, 0);
      do_span(9, 700, 0);
      do_span(17, -900, 0);
      do_span(0, 5000, 0);
      // R8: simultaneous tick and activity while busy.
      do_span(20, 1200, 1);

      // Random mix.
      for (int it = 0; it < 60; it++) begin
         if ($urandom_range(3) == 0) set_cut(int'($urandom_range(2047)));
         if ($urandom_range(3) == 0) begin
            set_res(int'($urandom_range(15)));
            chk("R4 q random", coef_q, q_of(m_res));
         end
         chk("R2 w1 random", coef_w1, w1_of(tab(m_code)));
         chk("R3 wdt random", coef_wdt, wdt_of(tab(m_code)));
         if ($urandom_range(1) == 0)
            do_tick(int'($urandom_range(16000)) - 8000);
         else
            do_span(int'($urandom_range(40)), int'($urandom_range(16000)) - 8000, 0);
      end

      // R10: reset in the middle of a span.
      span_req = 1; span_cycles = 16'd64; vin = 3000;
      @(negedge clk);
      span_req = 0;
      repeat (2) @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      m_hp = 0; m_bp = 0; m_lp = 0; m_code = 0; m_res = 0;
      chk("R10 busy cleared", busy, 0);
      chk("R10 done cleared", done, 0);
      chk("R10 code cleared", freq_addr, 0);
      chk_state("R10 mid-span reset");
      settle();
      chk("R10 resonance cleared", coef_q, 1448);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule